// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Controller

This controller produces the processor reset for a board and shares a single open-drain reset line with the processor and with any external reset source. Four things can start a reset: a supply that is not good, power-up, an expired watchdog, or a long enough low level that something outside the block pulls onto the line. The processor keeps the watchdog alive by pulling the same line briefly low through a divider. Each falling edge that the controller senses while it is not pulling the line itself counts as a strobe.

Analog detection happens outside this block, and it only receives digital results. The supply-good flag, the sensed line level and the watchdog-enable pin each pass through a synchronizer. Every time constant is a parameter counted in clock ticks. The block also gates the chip enable of a battery-backed memory and drives an active-low power-fail flag, so that the memory is write-protected while the supply is out of tolerance.

The reset output is an enable for an open-drain driver. When it is 1 the line is pulled low. When it is 0 the line is released, so other sources can wire-OR onto it.

Top module: `supply_supervisor`

## Requirements
- R1: Once the synchronized supply-good flag is false, `rst_line_pull_o` is 1 no later than the second rising clock edge after `supply_ok_i` falls. It stays 1 for as long as the supply is bad.
- R2: After the supply returns, and likewise after `rst_n` is released, `rst_line_pull_o` stays 1 for `HOLD_TICKS` cycles once the synchronized supply-good flag is true, and then returns to 0. While `rst_n` is low, `rst_line_pull_o` is 1.
- R3: `ce_out_n_o` equals `ce_in_n_i` while the synchronized supply is good. Otherwise it is 1, which write-protects the memory.
- R4: `pfail_n_o` is 1 while the synchronized supply is good and 0 otherwise, including during `rst_n`.
- R5: A strobe is a high-to-low change of the synchronized line level, seen while the block is not pulling the line and not in its short blanking window after a pull. A strobe restarts the watchdog, so strobes spaced less than `WD_TICKS` cycles apart keep the line released.
- R6: If the line stays high for `WD_TICKS` cycles with no strobe, the block pulls it for exactly `HOLD_TICKS` cycles. The block's own pulls are never taken as strobes, so these pulses repeat about every `WD_TICKS` cycles until a strobe arrives.
- R7: While `wd_enable_i` is 0, no watchdog pulse is produced. Supply-driven resets still occur.
- R8: A low on the line from an external source that lasts fewer than `QUAL_TICKS` cycles produces no reset.
- R9: An external low that lasts at least `QUAL_TICKS` cycles starts a pull of exactly `HOLD_TICKS` cycles.
- R10: If the external low is still present when the pull ends, the block produces no further pulse until the line has gone high. The watchdog then starts timing from that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok_i | input | 1 | Asynchronous supply-good flag from the comparator |
| wd_enable_i | input | 1 | Asynchronous watchdog enable, 0 disables watchdog resets |
| ce_in_n_i | input | 1 | Active-low memory chip enable from the address decoder |
| rst_line_i | input | 1 | Asynchronous sensed level of the shared reset line |
| rst_line_pull_o | output | 1 | 1 pulls the reset line low, 0 releases it |
| ce_out_n_o | output | 1 | Gated active-low memory chip enable |
| pfail_n_o | output | 1 | Power-fail flag, low while the supply is bad |

## Verification
The watchdog is driven with strobe spacings on both sides of the timeout. This separates a working restart from a counter that ignores strobes or fires early, and it also measures the repeat interval of unattended pulses. External lows are swept in length across the qualification threshold, one cycle at a time, which locates the exact count at which a reset starts. An external low held far past the pulse shows whether the block re-triggers on the level it cannot tell apart from its own pull. Supply drops are applied with the watchdog disabled, which separates the supply path, chip-enable gating and power-fail flag from the watchdog path.

// File: rtl/ss_pkg.sv
// Shared types for the supply supervisor.
// Holds the bundle of asynchronous inputs that are synchronized together,
// and the value that bundle takes in reset.
package ss_pkg;

    // Asynchronous inputs sampled by the shared synchronizer
    typedef struct packed {
        logic supply_ok;   // digitized supply-good flag
        logic line;        // sensed level of the shared reset line
        logic wd_en;       // watchdog enable pin
    } ss_sense_t;

    localparam int SENSE_W = $bits(ss_sense_t);

    // Reset view: supply treated as bad, line as idle high, watchdog off
    localparam ss_sense_t SENSE_RST = '{supply_ok: 1'b0, line: 1'b1, wd_en: 1'b0};

endpackage

// File: rtl/ss_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous bits.
// Assumes that each bit is independent, so no bundle coherence is needed.
// STAGES selects a single flop or a shift chain. The reset value is a parameter.
module ss_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stg;

    if (STAGES == 1) begin : g_single
        // Single capture flop
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= {STAGES{RST_VAL}};
            else        stg <= d_i;
        end
    end else begin : g_chain
        // Shift chain, newest sample enters at index 0
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= {STAGES{RST_VAL}};
            else        stg <= {stg[STAGES-2:0], d_i};
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/ss_line_mon.sv
// Monitor for the shared reset line.
// It finds strobes (falling edges) and qualifies external lows that last
// QUAL_TICKS cycles. While the block pulls the line, and for BLANK_TICKS
// cycles afterwards, the sensed level is ignored, because the synchronizer
// still shows the block's own pull during that time. After a pull, an
// external request is accepted only once the line has been seen high again.
module ss_line_mon #(
    parameter int BLANK_TICKS = 4,
    parameter int QUAL_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,      // synchronized line level
    input  logic pulling,     // block currently pulls the line low
    output logic strobe_o,    // one-cycle watchdog strobe
    output logic ext_valid_o, // one-cycle qualified external request
    output logic idle_o       // line high and not blanked
);

    localparam int BW = $clog2(BLANK_TICKS + 1);
    localparam int QW = (QUAL_TICKS > 1) ? $clog2(QUAL_TICKS) : 1;
    localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_TICKS);
    localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_TICKS - 1);

    logic [BW-1:0] blank_cnt;
    logic [QW-1:0] qual_cnt;
    logic          line_d;
    logic          armed;
    logic          blanked;

    assign blanked = pulling | (blank_cnt != '0);

    // Blanking window: reload while pulling, count down after release
    always_ff @(posedge clk) begin
        if (!rst_n || pulling)     blank_cnt <= BLANK_LOAD;
        else if (blank_cnt != '0)  blank_cnt <= blank_cnt - 1'b1;
    end

    // Previous sensed level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) line_d <= 1'b1;
        else        line_d <= line_s;
    end

    // Arming: cleared by the block's own pull, set once the line is seen high
    always_ff @(posedge clk) begin
        if (!rst_n || pulling)      armed <= 1'b0;
        else if (!blanked && line_s) armed <= 1'b1;
    end

    // Qualification counter for consecutive external low cycles
    always_ff @(posedge clk) begin
        if (!rst_n || blanked || line_s || !armed) qual_cnt <= '0;
        else if (qual_cnt == QUAL_LAST)            qual_cnt <= '0;
        else                                       qual_cnt <= qual_cnt + 1'b1;
    end

    assign strobe_o    = line_d & ~line_s & ~blanked;
    assign ext_valid_o = armed & ~blanked & ~line_s & (qual_cnt == QUAL_LAST);
    assign idle_o      = ~blanked & line_s;

endmodule

// File: rtl/ss_watchdog.sv
// Watchdog timeout counter.
// It counts cycles while the line is idle and the watchdog is enabled.
// A strobe, a low line, a pull or the disable input returns it to zero.
// fire_o is high for one cycle when WD_TICKS idle cycles have passed.
module ss_watchdog #(
    parameter int WD_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    input  logic idle,
    input  logic strobe,
    output logic fire_o
);

    localparam int WW = $clog2(WD_TICKS);
    localparam logic [WW-1:0] WD_LAST = WW'(WD_TICKS - 1);

    logic [WW-1:0] cnt;
    logic          counting;

    assign counting = en_s & idle & ~strobe;

    // Timeout counter, wraps on expiry so that pulses repeat
    always_ff @(posedge clk) begin
        if (!rst_n || !counting) cnt <= '0;
        else if (cnt == WD_LAST) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    assign fire_o = counting & (cnt == WD_LAST);

endmodule

// File: rtl/ss_reset_seq.sv
// Reset pulse sequencer.
// A bad supply holds the pull active with the counter at zero. Once the
// supply is good, the pull lasts HOLD_TICKS cycles. A watchdog expiry or a
// qualified external request starts a new pull of the same length, but
// only while no pull is active.
module ss_reset_seq #(
    parameter int HOLD_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_s,
    input  logic wd_fire,
    input  logic ext_valid,
    output logic pull_o
);

    localparam int HW = $clog2(HOLD_TICKS);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

    logic [HW-1:0] cnt;
    logic          active;

    // Pulse state and length counter
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_s) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == HOLD_LAST) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (wd_fire || ext_valid) begin
            active <= 1'b1;
            cnt    <= '0;
        end
    end

    assign pull_o = active | ~supply_s;

endmodule

// File: rtl/supply_supervisor.sv
// Supply supervisor: reset, watchdog and memory write protection.
// Assumes the comparator outputs and the reset-line sense are asynchronous
// digital levels. All times are counted in clk ticks.
// The reset line is open-drain: rst_line_pull_o = 1 pulls it low.
module supply_supervisor
    import ss_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_TICKS  = 600_000,
    parameter int WD_TICKS    = 700_000,
    parameter int QUAL_TICKS  = 20_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic wd_enable_i,
    input  logic ce_in_n_i,
    input  logic rst_line_i,
    output logic rst_line_pull_o,
    output logic ce_out_n_o,
    output logic pfail_n_o
);

    localparam int BLANK_TICKS = SYNC_STAGES + 2;

    ss_sense_t raw_in;
    ss_sense_t sense_s;
    logic      sup_s;
    logic      wd_en_s;
    logic      strobe;
    logic      ext_valid;
    logic      line_idle;
    logic      wd_fire;
    logic      pull;

    assign raw_in = '{supply_ok: supply_ok_i, line: rst_line_i, wd_en: wd_enable_i};

    ss_sync #(
        .W(SENSE_W), .STAGES(SYNC_STAGES), .RST_VAL(SENSE_RST)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sense_s)
    );

    assign sup_s   = sense_s.supply_ok;
    assign wd_en_s = sense_s.wd_en;

    ss_line_mon #(
        .BLANK_TICKS(BLANK_TICKS), .QUAL_TICKS(QUAL_TICKS)
    ) u_line (
        .clk(clk), .rst_n(rst_n), .line_s(sense_s.line), .pulling(pull),
        .strobe_o(strobe), .ext_valid_o(ext_valid), .idle_o(line_idle)
    );

    ss_watchdog #(.WD_TICKS(WD_TICKS)) u_wdog (
        .clk(clk), .rst_n(rst_n), .en_s(wd_en_s), .idle(line_idle),
        .strobe(strobe), .fire_o(wd_fire)
    );

    ss_reset_seq #(.HOLD_TICKS(HOLD_TICKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .supply_s(sup_s), .wd_fire(wd_fire),
        .ext_valid(ext_valid), .pull_o(pull)
    );

    assign rst_line_pull_o = pull;
    assign ce_out_n_o      = ce_in_n_i | ~sup_s;
    assign pfail_n_o       = sup_s;

endmodule

// File: rtl/supply_supervisor_chk.sv
// Assertion checker for supply_supervisor, attached by bind.
// Counters track how long the pull has been high and how long the line
// has been idle at the ports. Properties compare these against the parameters.
module supply_supervisor_chk #(
    parameter int HOLD_TICKS = 64,
    parameter int WD_TICKS   = 64
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok_i,
    input logic rst_line_i,
    input logic rst_line_pull_o,
    input logic ce_out_n_o,
    input logic pfail_n_o,
    input logic sup_s,
    input logic wd_en_s,
    input logic wd_fire,
    input logic ext_valid
);

    localparam int HCW = $clog2(HOLD_TICKS + 1);
    localparam int ICW = $clog2(WD_TICKS + 1);

    logic [HCW-1:0] hi_cnt;
    logic [ICW-1:0] idle_cnt;

    // Consecutive cycles with the pull active, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !rst_line_pull_o)      hi_cnt <= '0;
        else if (hi_cnt != HCW'(HOLD_TICKS)) hi_cnt <= hi_cnt + 1'b1;
    end

    // Consecutive cycles with the line released and high, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || rst_line_pull_o || !rst_line_i) idle_cnt <= '0;
        else if (idle_cnt != ICW'(WD_TICKS))          idle_cnt <= idle_cnt + 1'b1;
    end

    p_supply_pull_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok_i && $past(!supply_ok_i)) |=> rst_line_pull_o);

    p_mem_protect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok_i && $past(!supply_ok_i)) |=> (ce_out_n_o && !pfail_n_o));

    p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_line_pull_o) |-> (hi_cnt >= HCW'(HOLD_TICKS)));

    p_wd_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_line_pull_o) && sup_s && !$past(ext_valid))
            |-> ($past(idle_cnt, 3) >= ICW'(WD_TICKS - 3)));

    p_wd_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en_s |-> !wd_fire);

endmodule

bind supply_supervisor supply_supervisor_chk #(
    .HOLD_TICKS(HOLD_TICKS), .WD_TICKS(WD_TICKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok_i), .rst_line_i(rst_line_i),
    .rst_line_pull_o(rst_line_pull_o), .ce_out_n_o(ce_out_n_o), .pfail_n_o(pfail_n_o),
    .sup_s(sup_s), .wd_en_s(wd_en_s), .wd_fire(wd_fire), .ext_valid(ext_valid)
);

// File: tb/supply_supervisor_test.sv
`timescale 1ns/1ps
// Bench for supply_supervisor using a small tick configuration.
// Models the open-drain line as a wire-AND of the block, the processor
// strobe and an external reset source. Widths and intervals are swept
// around the thresholds given by the requirements.
module supply_supervisor_test;

    localparam int HOLD = 40;
    localparam int WD   = 60;
    localparam int QUAL = 10;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n, supply_ok, wd_en, ce_in_n, ext_low, strobe_low;
    logic pull, ce_out_n, pfail_n;
    wire  line = ~(pull | ext_low | strobe_low);

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2 clk = ~clk;

    supply_supervisor #(
        .SYNC_STAGES(2), .HOLD_TICKS(HOLD), .WD_TICKS(WD), .QUAL_TICKS(QUAL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .wd_enable_i(wd_en),
        .ce_in_n_i(ce_in_n), .rst_line_i(line), .rst_line_pull_o(pull),
        .ce_out_n_o(ce_out_n), .pfail_n_o(pfail_n)
    );

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Run-time limit counts as a failed check
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == LIMIT) begin
            n_tests++;
            n_fail++;
            $display("FAIL run limit (all requirements): actual %0d expected < %0d", cyc, LIMIT);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input string what,
                             input int act, input int lo, input int hi);
        n_tests++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        strobe_low = 1'b1;
        tick(2);
        strobe_low = 1'b0;
    endtask

    // Count ticks until the pull reaches level v
    task automatic wait_pull(input logic v, input int max, output int c);
        c = 0;
        while (pull !== v && c < max) begin
            tick(1);
            c++;
        end
    endtask

    // Count sampled cycles with the pull active
    task automatic watch(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (pull === 1'b1) highs++;
        end
    endtask

    initial begin
        int c, r, r2, rises;
        logic prev;
        rst_n = 1'b0; supply_ok = 1'b1; wd_en = 1'b1; ce_in_n = 1'b1;
        ext_low = 1'b0; strobe_low = 1'b0;
        tick(3);
        check(pull === 1'b1, "R2", "pull during rst_n", int'(pull), 1);
        check(pfail_n === 1'b0, "R4", "power-fail during rst_n", int'(pfail_n), 0);
        check(ce_out_n === 1'b1, "R3", "chip enable during rst_n", int'(ce_out_n), 1);

        rst_n = 1'b1;
        wait_pull(1'b0, 10 * HOLD, c);
        check_rng("R2", "power-up hold length", c, HOLD, HOLD + 4);
        check(pfail_n === 1'b1, "R4", "power-fail with good supply", int'(pfail_n), 1);
        ce_in_n = 1'b0; tick(1);
        check(ce_out_n === 1'b0, "R3", "chip enable passes low", int'(ce_out_n), 0);
        ce_in_n = 1'b1; tick(1);
        check(ce_out_n === 1'b1, "R3", "chip enable passes high", int'(ce_out_n), 1);

        // R5: strobes spaced below the timeout keep the line released
        tick(4);
        r2 = 0;
        for (int k = 0; k < 6; k++) begin
            strobe();
            watch(WD - 8, r);
            r2 += r;
        end
        check(r2 == 0, "R5", "pulls with strobes at WD-6 spacing", r2, 0);

        // R6: timeout, pulse length, repeat interval
        strobe();
        wait_pull(1'b1, 3 * WD, c);
        check_rng("R6", "first timeout after strobe", c + 2, WD, WD + 8);
        wait_pull(1'b0, 3 * HOLD, c);
        check_rng("R6", "watchdog pulse length", c, HOLD, HOLD + 1);
        wait_pull(1'b1, 3 * WD, c);
        check_rng("R6", "repeat interval", c, WD, WD + 8);
        wait_pull(1'b0, 3 * HOLD, c);
        check_rng("R6", "repeated pulse length", c, HOLD, HOLD + 1);

        // R7: watchdog disabled, supply path still active
        wd_en = 1'b0;
        tick(6);
        watch(4 * WD, r);
        check(r == 0, "R7", "pulls with watchdog disabled", r, 0);
        ce_in_n = 1'b0;
        supply_ok = 1'b0;
        tick(2);
        check(pull === 1'b1, "R1", "pull two edges after supply loss", int'(pull), 1);
        check(pfail_n === 1'b0, "R4", "power-fail after supply loss", int'(pfail_n), 0);
        check(ce_out_n === 1'b1, "R3", "chip enable blocked", int'(ce_out_n), 1);
        tick(25);
        check(pull === 1'b1, "R1", "pull held while supply bad", int'(pull), 1);
        supply_ok = 1'b1;
        wait_pull(1'b0, 10 * HOLD, c);
        check_rng("R2", "hold after supply return", c, HOLD + 1, HOLD + 3);
        ce_in_n = 1'b1;
        wd_en = 1'b1;
        tick(6);

        // R8 / R9: sweep external low length across the qualification count
        for (int len = QUAL - 3; len <= QUAL + 2; len++) begin
            strobe();
            tick(6);
            ext_low = 1'b1;
            r = 0;
            for (int i = 0; i < len; i++) begin
                tick(1);
                if (pull === 1'b1) r++;
            end
            ext_low = 1'b0;
            watch(HOLD + 12, r2);
            r += r2;
            if (len < QUAL)
                check(r == 0, "R8", "short external low gives no pull", r, 0);
            else
                check_rng("R9", "qualified external pulse length", r, HOLD, HOLD + 1);
            tick(4);
        end

        // R10: external low held beyond the pulse
        strobe();
        tick(6);
        ext_low = 1'b1;
        rises = 0;
        prev = 1'b0;
        for (int i = 0; i < QUAL + HOLD + 30; i++) begin
            tick(1);
            if (pull === 1'b1 && prev === 1'b0) rises++;
            prev = pull;
        end
        check(rises == 1, "R10", "pulses during held external low", rises, 1);
        check(pull === 1'b0, "R10", "block released line while held", int'(pull), 0);
        check(line === 1'b0, "R10", "line still low from external source", int'(line), 0);
        ext_low = 1'b0;
        watch(WD - 10, r);
        check(r == 0, "R10", "no pull soon after release", r, 0);
        wait_pull(1'b1, 2 * WD, c);
        check_rng("R10", "watchdog restart from release", c + WD - 10, WD, WD + 8);
        wait_pull(1'b0, 3 * HOLD, c);

        summary();
    end

endmodule